// File: doc/BRIEF.md
# Reader Power-Mode Wake Sequencer

This block sequences the power states of a contactless reader front end. It watches a host enable line and a separate wake pin, together with a "supplies settled" flag from the regulators and a "crystal stable" flag from the oscillator. From these inputs it drives the regulator enable, the oscillator enable, the receiver enable and the RF transmitter enable. It also drives a select that chooses whether the system clock output carries the low-frequency auxiliary clock or the divided crystal clock. A separate keep-alive output holds the auxiliary supply and the auxiliary clock on.

There are two ways to start. The host can raise its enable line. Alternatively, a pulse on the wake pin can start the reader from full power-down while the host is still unpowered. In the pin-started case the host must confirm by raising its enable within a fixed window after the clock switches to the crystal. If it does not, the block falls back to power-down on its own. Once the host has confirmed, three mode bits from the host's control register select one of four operating modes:

- standby, with the oscillator stopped;
- idle, with RF off;
- receive-only;
- full RF.

Leaving standby or idle for an RF mode passes through a timed recovery state. When the recovery ends, a one-cycle ready strobe is raised. Both asynchronous pins pass through a two-flop synchronizer. All windows and recovery delays are counted in clock cycles.

Top module: `rdr_wake_seq`

## Requirements
- R1: After reset, and whenever the block is powered down, the regulator, oscillator, clock-select, receiver, transmitter and ready outputs are all 0. The keep-alive output is 0 as long as the wake pin is low.
- R2: From power-down, either of two events starts the regulators and the oscillator (reg_en_o=1, osc_en_o=1). One is a synchronized host enable at 1. The other is a rising edge on the wake pin while the host enable is 0. A wake pulse one clock period wide is enough.
- R3: During start-up, hf_clk_sel_o stays 0 (auxiliary clock) until supply_ok_i and xtal_ok_i are both 1. On that condition it becomes 1 (crystal clock).
- R4: While the wake pin is held high and the block is powered down, aux_on_o is 1. aux_on_o is also 1 in every powered state.
- R5: After a wake-pin start, if the synchronized host enable is not 1 during any of the WIN_CYC cycles after the clock switch, the block returns to power-down.
- R6: If the synchronized host enable is 1 inside that window, the block enters idle (regulators, oscillator and crystal clock on, RF off), and the mode bits then govern.
- R7: Mode bits decode as follows. mode_bits_i[2]=1 selects standby and has the highest priority. Otherwise mode_bits_i[1]=1 selects full RF (rx_en_o=1, tx_en_o=1). Otherwise mode_bits_i[0]=1 selects receive-only (rx_en_o=1, tx_en_o=0). Otherwise the mode is idle (both 0). Changes among idle, receive-only and full RF coming out of receive-only or full RF take effect in one cycle.
- R8: Standby keeps the regulators on and turns the oscillator off (osc_en_o=0, hf_clk_sel_o=0). Leaving standby takes STBY_REC_CYC recovery cycles: the oscillator is on, the auxiliary clock is selected and RF is off. Going from idle to an RF mode takes IDLE_REC_CYC recovery cycles with the crystal clock selected and RF off.
- R9: ready_o is 1 for exactly one cycle, the first cycle after a recovery ends in a mode other than standby. It stays 0 otherwise, including on direct changes between receive-only and full RF.
- R10: In any powered state, except start-up and the confirm window of a wake-pin start, a synchronized host enable of 0 returns the block to power-down.
- R11: A change on host_en_i or wake_pin_i that is set up before a rising clock edge first acts on the state at the third rising edge. The state-driven outputs change just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en_i | input | 1 | Host enable line, asynchronous |
| wake_pin_i | input | 1 | Wake pin, asynchronous; a rising edge starts the reader |
| supply_ok_i | input | 1 | Regulators have settled |
| xtal_ok_i | input | 1 | Crystal oscillator is stable |
| mode_bits_i | input | 3 | [2] standby, [1] full RF, [0] receive-only |
| reg_en_o | output | 1 | Regulator enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| hf_clk_sel_o | output | 1 | 1 selects the crystal-derived clock, 0 the auxiliary clock |
| aux_on_o | output | 1 | Keeps the auxiliary supply and auxiliary clock running |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | RF transmitter enable |
| ready_o | output | 1 | One-cycle strobe when recovery reaches the selected mode |

## Verification
The bench builds the block with an 8-cycle confirm window, a 6-cycle standby recovery and a 3-cycle idle recovery. The defaults are 1356, 1356 and 339 cycles, which correspond to 100 µs and 25 µs at 13.56 MHz. With the short settings, window expiry and both recovery paths complete within a few dozen cycles. The bench can then sweep the host confirmation over every offset from before the window opens to past its last cycle, so the exact boundary cycle on both sides is exercised. The same short settings let one run cover standby priority, repeated recoveries with their ready strobes, and host drop-out from every powered state.

// File: rtl/rdr_wake_pkg.sv
package rdr_wake_pkg;

  typedef enum logic [3:0] {
    S_OFF      = 4'd0,
    S_START    = 4'd1,
    S_CONFIRM  = 4'd2,
    S_IDLE     = 4'd3,
    S_STBY     = 4'd4,
    S_REC_SLOW = 4'd5,
    S_REC_FAST = 4'd6,
    S_RX       = 4'd7,
    S_FULL     = 4'd8
  } wake_state_e;

  typedef enum logic [1:0] {
    OM_IDLE = 2'd0,
    OM_RX   = 2'd1,
    OM_FULL = 2'd2,
    OM_STBY = 2'd3
  } op_mode_e;

  typedef struct packed {
    logic reg_en;
    logic osc_en;
    logic hf_sel;
    logic aux_on;
    logic rx_en;
    logic tx_en;
  } pwr_ctl_t;

  function automatic wake_state_e mode_to_state(op_mode_e m);
    case (m)
      OM_STBY: return S_STBY;
      OM_FULL: return S_FULL;
      OM_RX:   return S_RX;
      default: return S_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rdr_wake_sync.sv
module rdr_wake_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/rdr_wake_timer.sv
module rdr_wake_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rdr_wake_mode_dec.sv
module rdr_wake_mode_dec
  import rdr_wake_pkg::*;
(
  input  logic [2:0] mode_bits_i,
  output op_mode_e   mode_o
);
  always_comb begin
    if (mode_bits_i[2])      mode_o = OM_STBY;
    else if (mode_bits_i[1]) mode_o = OM_FULL;
    else if (mode_bits_i[0]) mode_o = OM_RX;
    else                     mode_o = OM_IDLE;
  end
endmodule

// File: rtl/rdr_wake_ctl_map.sv
module rdr_wake_ctl_map
  import rdr_wake_pkg::*;
(
  input  wake_state_e state_i,
  input  logic        wake_lvl_i,
  output pwr_ctl_t    ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (state_i)
      S_START, S_REC_SLOW: begin
        ctl_o.reg_en = 1'b1;
        ctl_o.osc_en = 1'b1;
      end
      S_CONFIRM, S_IDLE, S_REC_FAST: begin
        ctl_o.reg_en = 1'b1;
        ctl_o.osc_en = 1'b1;
        ctl_o.hf_sel = 1'b1;
      end
      S_STBY: ctl_o.reg_en = 1'b1;
      S_RX: begin
        ctl_o.reg_en = 1'b1;
        ctl_o.osc_en = 1'b1;
        ctl_o.hf_sel = 1'b1;
        ctl_o.rx_en  = 1'b1;
      end
      S_FULL: begin
        ctl_o.reg_en = 1'b1;
        ctl_o.osc_en = 1'b1;
        ctl_o.hf_sel = 1'b1;
        ctl_o.rx_en  = 1'b1;
        ctl_o.tx_en  = 1'b1;
      end
      default: ctl_o = '0;
    endcase
    ctl_o.aux_on = (state_i != S_OFF) | wake_lvl_i;
  end
endmodule

// File: rtl/rdr_wake_seq.sv
module rdr_wake_seq
  import rdr_wake_pkg::*;
#(
  parameter int WIN_CYC      = 1356,
  parameter int STBY_REC_CYC = 1356,
  parameter int IDLE_REC_CYC = 339,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_en_i,
  input  logic       wake_pin_i,
  input  logic       supply_ok_i,
  input  logic       xtal_ok_i,
  input  logic [2:0] mode_bits_i,
  output logic       reg_en_o,
  output logic       osc_en_o,
  output logic       hf_clk_sel_o,
  output logic       aux_on_o,
  output logic       rx_en_o,
  output logic       tx_en_o,
  output logic       ready_o
);
  localparam int MAX_A = (WIN_CYC > STBY_REC_CYC) ? WIN_CYC : STBY_REC_CYC;
  localparam int MAX_C = (MAX_A > IDLE_REC_CYC) ? MAX_A : IDLE_REC_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] WIN_LEN  = CW'(WIN_CYC);
  localparam logic [CW-1:0] SREC_LEN = CW'(STBY_REC_CYC);
  localparam logic [CW-1:0] FREC_LEN = CW'(IDLE_REC_CYC);

  logic [1:0]  pins_sync;
  logic        host_lvl, wake_lvl, wake_prev_q, wake_rise;
  wake_state_e state_q, nxt_state;
  logic        from_pin_q, pin_d;
  logic        rdy_q, rdy_d;
  logic        tmr_load, tmr_exp;
  logic [CW-1:0] tmr_len;
  logic        clk_ok, host_drop;
  op_mode_e    mode;
  pwr_ctl_t    ctl;

  rdr_wake_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({wake_pin_i, host_en_i}),
    .sync_o(pins_sync)
  );
  assign host_lvl = pins_sync[0];
  assign wake_lvl = pins_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_prev_q <= 1'b0;
    else        wake_prev_q <= wake_lvl;
  end
  assign wake_rise = wake_lvl & ~wake_prev_q;

  rdr_wake_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load_i(tmr_load), .len_i(tmr_len), .expired_o(tmr_exp)
  );

  rdr_wake_mode_dec u_dec (.mode_bits_i(mode_bits_i), .mode_o(mode));

  assign clk_ok    = supply_ok_i & xtal_ok_i;
  assign host_drop = ~host_lvl &
                     ~(from_pin_q & ((state_q == S_START) | (state_q == S_CONFIRM)));

  always_comb begin
    nxt_state = state_q;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    rdy_d     = 1'b0;
    pin_d     = from_pin_q;
    case (state_q)
      S_OFF: begin
        if (host_lvl) begin
          nxt_state = S_START;
          pin_d     = 1'b0;
        end else if (wake_rise) begin
          nxt_state = S_START;
          pin_d     = 1'b1;
        end
      end
      S_START: begin
        if (clk_ok) begin
          if (host_lvl) begin
            nxt_state = S_IDLE;
            pin_d     = 1'b0;
          end else begin
            nxt_state = S_CONFIRM;
            tmr_load  = 1'b1;
            tmr_len   = WIN_LEN;
          end
        end
      end
      S_CONFIRM: begin
        if (host_lvl) begin
          nxt_state = S_IDLE;
          pin_d     = 1'b0;
        end else if (tmr_exp) begin
          nxt_state = S_OFF;
          pin_d     = 1'b0;
        end
      end
      S_IDLE: begin
        if (mode == OM_STBY) nxt_state = S_STBY;
        else if (mode != OM_IDLE) begin
          nxt_state = S_REC_FAST;
          tmr_load  = 1'b1;
          tmr_len   = FREC_LEN;
        end
      end
      S_STBY: begin
        if (mode != OM_STBY) begin
          nxt_state = S_REC_SLOW;
          tmr_load  = 1'b1;
          tmr_len   = SREC_LEN;
        end
      end
      S_REC_SLOW, S_REC_FAST: begin
        if (tmr_exp) begin
          nxt_state = mode_to_state(mode);
          rdy_d     = (mode != OM_STBY);
        end
      end
      S_RX, S_FULL: nxt_state = mode_to_state(mode);
      default: nxt_state = S_OFF;
    endcase
    if ((state_q != S_OFF) && host_drop) begin
      nxt_state = S_OFF;
      tmr_load  = 1'b0;
      rdy_d     = 1'b0;
      pin_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_OFF;
      from_pin_q <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      state_q    <= nxt_state;
      from_pin_q <= pin_d;
      rdy_q      <= rdy_d;
    end
  end

  rdr_wake_ctl_map u_map (.state_i(state_q), .wake_lvl_i(wake_lvl), .ctl_o(ctl));

  assign reg_en_o     = ctl.reg_en;
  assign osc_en_o     = ctl.osc_en;
  assign hf_clk_sel_o = ctl.hf_sel;
  assign aux_on_o     = ctl.aux_on;
  assign rx_en_o      = ctl.rx_en;
  assign tx_en_o      = ctl.tx_en;
  assign ready_o      = rdy_q;
endmodule

// File: rtl/rdr_wake_seq_chk.sv
module rdr_wake_seq_chk
  import rdr_wake_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input wake_state_e state_q,
  input logic        from_pin_q,
  input logic        host_lvl,
  input logic        supply_ok_i,
  input logic        xtal_ok_i,
  input logic        reg_en_o,
  input logic        osc_en_o,
  input logic        hf_clk_sel_o,
  input logic        aux_on_o,
  input logic        rx_en_o,
  input logic        tx_en_o,
  input logic        ready_o
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_OFF) |-> (!reg_en_o && !osc_en_o && !hf_clk_sel_o && !rx_en_o && !tx_en_o));

  p_aux_clock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && !(supply_ok_i && xtal_ok_i)) |=> !hf_clk_sel_o);

  p_keepalive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en_o |-> aux_on_o);

  p_tx_implies_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> rx_en_o);

  p_rf_on_crystal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_o |-> (osc_en_o && hf_clk_sel_o));

  p_standby_osc_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STBY) |-> (!osc_en_o && reg_en_o));

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  p_host_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_OFF && !from_pin_q && !host_lvl) |=> (state_q == S_OFF));
endmodule

bind rdr_wake_seq rdr_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .from_pin_q(from_pin_q),
  .host_lvl(host_lvl), .supply_ok_i(supply_ok_i), .xtal_ok_i(xtal_ok_i),
  .reg_en_o(reg_en_o), .osc_en_o(osc_en_o), .hf_clk_sel_o(hf_clk_sel_o),
  .aux_on_o(aux_on_o), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .ready_o(ready_o)
);

// File: tb/rdr_wake_seq_test.sv
module rdr_wake_seq_test;
  localparam int PERIOD = 10;
  localparam int WIN  = 8;
  localparam int SREC = 6;
  localparam int FREC = 3;

  logic clk = 1'b0, rst_n = 1'b0, host = 1'b0, wake = 1'b0, sup = 1'b0, xtal = 1'b0;
  logic [2:0] mb = 3'b000;
  logic reg_en, osc_en, hf_sel, aux_on, rx_en, tx_en, ready;

  rdr_wake_seq #(.WIN_CYC(WIN), .STBY_REC_CYC(SREC), .IDLE_REC_CYC(FREC)) uut (
    .clk(clk), .rst_n(rst_n), .host_en_i(host), .wake_pin_i(wake),
    .supply_ok_i(sup), .xtal_ok_i(xtal), .mode_bits_i(mb),
    .reg_en_o(reg_en), .osc_en_o(osc_en), .hf_clk_sel_o(hf_sel), .aux_on_o(aux_on),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .ready_o(ready)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, rdy_cnt = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model: behavioural, one step per rising edge
  localparam int M_OFF = 0, M_ST = 1, M_CF = 2, M_ID = 3, M_SB = 4,
                 M_RS = 5, M_RF = 6, M_RX = 7, M_FU = 8;
  int ms, mc, mw;
  bit mpin, mrdy, h1, h2, w1, w2, w3, hl, wr;

  function automatic int want(logic [2:0] b);
    if (b[2]) return M_SB;
    if (b[1]) return M_FU;
    if (b[0]) return M_RX;
    return M_ID;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = M_OFF; mc = 0; mpin = 0; mrdy = 0;
      h1 = 0; h2 = 0; w1 = 0; w2 = 0; w3 = 0;
    end else begin
      hl = h2; wr = w2 && !w3; mw = want(mb); mrdy = 0;
      if (ms != M_OFF && !hl && !(mpin && (ms == M_ST || ms == M_CF))) begin
        ms = M_OFF; mpin = 0;
      end else begin
        case (ms)
          M_OFF: if (hl) begin ms = M_ST; mpin = 0; end
                 else if (wr) begin ms = M_ST; mpin = 1; end
          M_ST:  if (sup && xtal) begin
                   if (hl) begin ms = M_ID; mpin = 0; end
                   else begin ms = M_CF; mc = WIN - 1; end
                 end
          M_CF:  if (hl) begin ms = M_ID; mpin = 0; end
                 else if (mc == 0) begin ms = M_OFF; mpin = 0; end
                 else mc--;
          M_ID:  if (mw == M_SB) ms = M_SB;
                 else if (mw != M_ID) begin ms = M_RF; mc = FREC - 1; end
          M_SB:  if (mw != M_SB) begin ms = M_RS; mc = SREC - 1; end
          M_RS, M_RF: if (mc == 0) begin mrdy = (mw != M_SB); ms = mw; end
                      else mc--;
          default: ms = mw;
        endcase
      end
      w3 = w2; w2 = w1; w1 = wake; h2 = h1; h1 = host;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "reg_en", reg_en, ms != M_OFF);
      chk("R8", "osc_en", osc_en, ms != M_OFF && ms != M_SB);
      chk("R3", "hf_sel", hf_sel,
          ms == M_CF || ms == M_ID || ms == M_RF || ms == M_RX || ms == M_FU);
      chk("R4", "aux_on", aux_on, ms != M_OFF || w2);
      chk("R7", "rx_en", rx_en, ms == M_RX || ms == M_FU);
      chk("R7", "tx_en", tx_en, ms == M_FU);
      chk("R9", "ready", ready, mrdy);
      if (ready) rdy_cnt++;
    end
  end

  initial begin
    cyc(3);
    chk("R1", "reg_en in reset", reg_en, 0);
    chk("R1", "aux_on in reset", aux_on, 0);
    chk("R1", "ready in reset", ready, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "hf_sel after reset", hf_sel, 0);

    // wake held high, clock not yet good
    wake = 1'b1;
    cyc(4);
    chk("R2", "reg_en on wake edge", reg_en, 1);
    chk("R2", "osc_en on wake edge", osc_en, 1);
    chk("R3", "hf_sel before settle", hf_sel, 0);
    sup = 1'b1;
    cyc(3);
    chk("R3", "hf_sel with supply only", hf_sel, 0);
    xtal = 1'b1;
    cyc(2);
    chk("R3", "hf_sel after settle", hf_sel, 1);
    cyc(WIN + 3);
    chk("R5", "reg_en after window", reg_en, 0);
    chk("R4", "aux_on wake held", aux_on, 1);
    wake = 1'b0;
    cyc(1);
    chk("R11", "aux_on one edge after fall", aux_on, 1);
    cyc(2);
    chk("R4", "aux_on wake low", aux_on, 0);

    // single-cycle wake pulse, confirmed
    wake = 1'b1; cyc(1); wake = 1'b0;
    cyc(4);
    host = 1'b1;
    cyc(4);
    chk("R6", "reg_en confirmed", reg_en, 1);
    chk("R6", "hf_sel confirmed", hf_sel, 1);
    chk("R6", "rx_en idle", rx_en, 0);

    rdy_cnt = 0;
    mb = 3'b001;
    cyc(FREC + 5);
    chk("R7", "rx_en rx-only", rx_en, 1);
    chk("R7", "tx_en rx-only", tx_en, 0);
    chk("R9", "ready count idle->rx", rdy_cnt, 1);
    mb = 3'b011;
    cyc(2);
    chk("R7", "tx_en full", tx_en, 1);
    chk("R9", "no ready rx->full", rdy_cnt, 1);
    mb = 3'b110;
    cyc(2);
    chk("R7", "standby priority tx", tx_en, 0);
    chk("R8", "standby osc", osc_en, 0);
    chk("R8", "standby hf", hf_sel, 0);
    mb = 3'b010;
    cyc(3);
    chk("R8", "slow recovery osc", osc_en, 1);
    chk("R8", "slow recovery tx", tx_en, 0);
    cyc(SREC + 2);
    chk("R8", "after slow recovery tx", tx_en, 1);
    chk("R9", "ready count after standby", rdy_cnt, 2);
    mb = 3'b000;
    cyc(2);
    chk("R7", "idle rx", rx_en, 0);
    chk("R7", "idle hf", hf_sel, 1);
    mb = 3'b010;
    cyc(2);
    chk("R8", "fast recovery tx", tx_en, 0);
    cyc(FREC + 2);
    chk("R8", "after fast recovery tx", tx_en, 1);
    chk("R9", "ready count fast", rdy_cnt, 3);
    host = 1'b0;
    cyc(1);
    chk("R11", "reg_en before sync", reg_en, 1);
    cyc(3);
    chk("R10", "reg_en after host drop", reg_en, 0);

    // host start, crystal not stable, then host drop during start-up
    xtal = 1'b0; mb = 3'b000;
    host = 1'b1;
    cyc(4);
    chk("R2", "host start reg_en", reg_en, 1);
    chk("R3", "host start hf", hf_sel, 0);
    host = 1'b0;
    cyc(4);
    chk("R10", "drop in start-up", reg_en, 0);

    // exact latency
    xtal = 1'b1;
    host = 1'b1;
    cyc(2);
    chk("R11", "reg_en after two edges", reg_en, 0);
    cyc(1);
    chk("R11", "reg_en after third edge", reg_en, 1);
    cyc(2);
    chk("R6", "host start idle hf", hf_sel, 1);
    host = 1'b0;
    cyc(5);

    // confirm-window boundary sweep
    for (int d = 0; d <= WIN + 4; d++) begin
      wake = 1'b1; cyc(1); wake = 1'b0;
      cyc(d);
      host = 1'b1;
      cyc(6);
      host = 1'b0;
      cyc(WIN + 6);
      chk("R5", "off after sweep step", reg_en, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule